// File: doc/BRIEF.md
# Twin-Predicated Register Move Sequencer

This block steps through a vectorised register move in which the source and the destination each have a predicate mask of their own. A caller gives it a vector length, a base register for each side, a flag for each side saying whether that side is a vector or a scalar, and one mask per side. The block then emits one register-copy request per cycle as a pair of register numbers: the source register and the destination register.

Each side keeps its own element index. A vector side skips over element positions whose mask bit is clear before each copy, and moves forward by one after each copy. A scalar side always points at its base register. The flags and masks alone select the kind of move:
- scalar source into a vector destination gives a splat, or a sparse splat when the destination mask has gaps;
- a destination mask with a single bit set gives an insert;
- a vector source into a scalar destination, with a single source bit set, gives an extract;
- two vectors give a copy, a gather, a scatter or a gather-scatter, depending on the masks.

The register file and the lookup that produces the masks live outside this block.

The controller has three states:
- **IDLE**: waits for `start`.
- **STEP**: evaluates one element pair per cycle.
- **FINISH**: used only after the single copy of a scalar-to-scalar move.

Its transitions are:
- **IDLE→STEP** on `start`.
- **STEP→STEP** after a copy while a vector side remains.
- **STEP→FINISH** after the copy of a scalar-to-scalar move.
- **STEP→IDLE** when an index runs out. This transition raises `done`.
- **FINISH→IDLE**. This transition also raises `done`.

Top module: `twin_pred_mv_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `copy_valid` and `done` are 0.
- R2: `start` is sampled only in IDLE, where all operands are captured. Operand changes and `start` pulses while `busy` is 1 have no effect on the copies issued, and no new move begins.
- R3: For a vector source, the source index starts at 0 and, before each copy, advances to the lowest position at or above it whose `src_mask` bit (bit p for element p) is 1. The copy names register `src_base` + index, and the index then moves past that position.
- R4: For a vector destination, the destination index behaves the same way with `dst_mask`, and the copy names register `dst_base` + index.
- R5: A scalar side always names its base register, and its mask has no effect.
- R6: When both sides are scalar and the length is at least 1, exactly one copy `src_base`→`dst_base` is issued.
- R7: The move ends without a further copy as soon as either index, after skipping, reaches the length. A length of 0 or an all-clear vector mask yields no copy, and mask bits at positions at or above the length are ignored.
- R8: The first copy appears in the cycle after the first rising edge following the edge that sampled `start`. Later copies follow on consecutive cycles, at most one per cycle, and `copy_valid` is 1 only while `busy` is 1.
- R9: `done` is a one-cycle pulse in the cycle right after the last copy, or in the second cycle after `start` when no copy is issued. In the `done` cycle, `busy` is already 0.
- R10: A length above `MAXVL` is treated as `MAXVL`.
- R11: Register numbers wrap modulo 2^`REG_AW` (32 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a move (taken in IDLE only) |
| vl | input | $clog2(MAXVL+1) | Vector length |
| src_base | input | REG_AW | Source base register |
| dst_base | input | REG_AW | Destination base register |
| src_vec | input | 1 | 1 = source is a vector |
| dst_vec | input | 1 | 1 = destination is a vector |
| src_mask | input | MAXVL | Source predicate, bit p for element p |
| dst_mask | input | MAXVL | Destination predicate, bit p for element p |
| busy | output | 1 | A move is in progress |
| copy_valid | output | 1 | A copy request is presented this cycle |
| copy_src | output | REG_AW | Source register of the copy |
| copy_dst | output | REG_AW | Destination register of the copy |
| done | output | 1 | One-cycle end-of-move pulse |

## Verification
Once `start` has been sampled at edge s, copy k is due on the cycle after edge s+1+k. For a move of n copies, `done` is due on the cycle after edge s+1+n, with n = 0 when the move issues no copy. The bench drives inputs and samples outputs on falling edges only. It counts falling edges from the one where `start` is lowered and expects copy k at sample k and `done` at sample n, checking `copy_valid` and `done` at every sample in between. One scenario also alters all operands and pulses `start` mid-move. It then confirms that the copy list is unchanged and that the block stays idle afterwards.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STEP   = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_e;
endpackage

// File: rtl/tpm_idx_skip.sv
// Finds the next usable element position for one side of the move.
module tpm_idx_skip #(
    parameter int MAXVL = 16,
    parameter int VLW   = $clog2(MAXVL + 1)
) (
    input  logic [VLW-1:0]   cur,
    input  logic [VLW-1:0]   lim,
    input  logic             is_vec,
    input  logic [MAXVL-1:0] mask,
    output logic [VLW-1:0]   pos,
    output logic             hit
);
    always_comb begin
        pos = lim;
        hit = 1'b0;
        if (!is_vec) begin
            // scalar side: no skipping, index never moves (R5)
            pos = cur;
            hit = (cur < lim);
        end else begin
            // lowest set bit in [cur, lim) wins (R3, R4, R7)
            for (int p = MAXVL - 1; p >= 0; p--) begin
                if (mask[p] && (VLW'(p) >= cur) && (VLW'(p) < lim)) begin
                    pos = VLW'(p);
                    hit = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tpm_reg_addr.sv
// Base plus element index, wrapping modulo the register count (R11).
module tpm_reg_addr #(
    parameter int REG_AW = 5,
    parameter int VLW    = 5
) (
    input  logic [REG_AW-1:0] base,
    input  logic [VLW-1:0]    idx,
    output logic [REG_AW-1:0] reg_no
);
    logic [REG_AW+VLW-1:0] sum;

    always_comb begin
        sum    = {{VLW{1'b0}}, base} + {{REG_AW{1'b0}}, idx};
        reg_no = sum[REG_AW-1:0];
    end
endmodule

// File: rtl/twin_pred_mv_seq.sv
module twin_pred_mv_seq
    import tpm_pkg::*;
#(
    parameter int MAXVL  = 16,
    parameter int REG_AW = 5,
    localparam int VLW   = $clog2(MAXVL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VLW-1:0]    vl,
    input  logic [REG_AW-1:0] src_base,
    input  logic [REG_AW-1:0] dst_base,
    input  logic              src_vec,
    input  logic              dst_vec,
    input  logic [MAXVL-1:0]  src_mask,
    input  logic [MAXVL-1:0]  dst_mask,
    output logic              busy,
    output logic              copy_valid,
    output logic [REG_AW-1:0] copy_src,
    output logic [REG_AW-1:0] copy_dst,
    output logic              done
);
    seq_state_e state, state_d;

    logic [VLW-1:0]    vl_q, i_q, j_q;
    logic [REG_AW-1:0] sb_q, db_q;
    logic              sv_q, dv_q;
    logic [MAXVL-1:0]  sm_q, dm_q;

    logic [VLW-1:0]    ni, nj;
    logic              hit_i, hit_j, go;
    logic [REG_AW-1:0] src_reg, dst_reg;
    logic [VLW-1:0]    vl_clamped;

    // R10: lengths beyond the supported maximum are clamped
    assign vl_clamped = (vl > VLW'(MAXVL)) ? VLW'(MAXVL) : vl;

    tpm_idx_skip #(.MAXVL(MAXVL), .VLW(VLW)) u_skip_src (
        .cur(i_q), .lim(vl_q), .is_vec(sv_q), .mask(sm_q), .pos(ni), .hit(hit_i)
    );
    tpm_idx_skip #(.MAXVL(MAXVL), .VLW(VLW)) u_skip_dst (
        .cur(j_q), .lim(vl_q), .is_vec(dv_q), .mask(dm_q), .pos(nj), .hit(hit_j)
    );
    tpm_reg_addr #(.REG_AW(REG_AW), .VLW(VLW)) u_addr_src (
        .base(sb_q), .idx(ni), .reg_no(src_reg)
    );
    tpm_reg_addr #(.REG_AW(REG_AW), .VLW(VLW)) u_addr_dst (
        .base(db_q), .idx(nj), .reg_no(dst_reg)
    );

    assign go   = hit_i && hit_j;
    assign busy = (state != ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:   if (start) state_d = ST_STEP;
            ST_STEP: begin
                if (!go)                state_d = ST_IDLE;    // R7
                else if (!sv_q && !dv_q) state_d = ST_FINISH; // R6
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            copy_valid <= 1'b0;
            copy_src   <= '0;
            copy_dst   <= '0;
            done       <= 1'b0;
            vl_q       <= '0;
            i_q        <= '0;
            j_q        <= '0;
            sb_q       <= '0;
            db_q       <= '0;
            sv_q       <= 1'b0;
            dv_q       <= 1'b0;
            sm_q       <= '0;
            dm_q       <= '0;
        end else begin
            copy_valid <= 1'b0;
            done       <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin   // R2: capture only here
                        vl_q <= vl_clamped;
                        sb_q <= src_base;
                        db_q <= dst_base;
                        sv_q <= src_vec;
                        dv_q <= dst_vec;
                        sm_q <= src_mask;
                        dm_q <= dst_mask;
                        i_q  <= '0;
                        j_q  <= '0;
                    end
                end
                ST_STEP: begin
                    if (go) begin
                        copy_valid <= 1'b1;
                        copy_src   <= src_reg;
                        copy_dst   <= dst_reg;
                        i_q        <= ni + VLW'(sv_q);
                        j_q        <= nj + VLW'(dv_q);
                    end else begin
                        done <= 1'b1;
                    end
                end
                ST_FINISH: done <= 1'b1;
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    a_r8_copy_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        copy_valid |-> busy);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !copy_valid));

    a_r7_src_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (i_q <= vl_q && j_q <= vl_q));

    a_r5_scalar_src_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sv_q) |-> (i_q == '0));

    a_r5_scalar_dst_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dv_q) |-> (j_q == '0));

    a_r3_src_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STEP && go && sv_q) |-> (((sm_q >> ni) & MAXVL'(1)) != '0));

    a_r4_dst_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STEP && go && dv_q) |-> (((dm_q >> nj) & MAXVL'(1)) != '0));

    a_r2_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(vl_q) && $stable(sb_q) && $stable(db_q)));
endmodule

// File: tb/twin_pred_mv_seq_tb_top.sv
module twin_pred_mv_seq_tb_top;
    localparam int MAXVL  = 16;
    localparam int REG_AW = 5;
    localparam int VLW    = $clog2(MAXVL + 1);

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [VLW-1:0]    vl;
    logic [REG_AW-1:0] src_base, dst_base;
    logic              src_vec, dst_vec;
    logic [MAXVL-1:0]  src_mask, dst_mask;
    logic              busy, copy_valid, done;
    logic [REG_AW-1:0] copy_src, copy_dst;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #4 clk = ~clk; // 125 MHz

    twin_pred_mv_seq #(.MAXVL(MAXVL), .REG_AW(REG_AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
        .src_base(src_base), .dst_base(dst_base),
        .src_vec(src_vec), .dst_vec(dst_vec),
        .src_mask(src_mask), .dst_mask(dst_mask),
        .busy(busy), .copy_valid(copy_valid),
        .copy_src(copy_src), .copy_dst(copy_dst), .done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_op(input string req, input int tvl, input int sb, input int db,
                          input bit sv, input bit dv, input int sm, input int dm,
                          input bit scramble);
        int es[64];
        int ed[64];
        int n = 0;
        int lim = (tvl > MAXVL) ? MAXVL : tvl;   // R10
        int i = 0;
        int j = 0;
        // expected copy list from the requirements
        for (int g = 0; g < 40; g++) begin
            if (sv) while (i < lim && ((sm >> i) & 1) == 0) i++;
            if (dv) while (j < lim && ((dm >> j) & 1) == 0) j++;
            if (i >= lim || j >= lim) break;
            es[n] = (sb + i) % 32;
            ed[n] = (db + j) % 32;
            n++;
            if (sv) i++;
            if (dv) j++;
            if (!sv && !dv) break;
        end

        @(negedge clk);
        vl = VLW'(tvl); src_base = REG_AW'(sb); dst_base = REG_AW'(db);
        src_vec = sv; dst_vec = dv;
        src_mask = MAXVL'(sm); dst_mask = MAXVL'(dm);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin // R2: changes while busy
            vl = 5'd3; src_base = 5'd7; dst_base = 5'd9;
            src_vec = ~sv; dst_vec = ~dv; src_mask = '0; dst_mask = '0;
        end
        for (int k = 0; k < 70; k++) begin
            @(negedge clk);
            if (scramble && k == 0) start = 1'b1;
            if (scramble && k == 1) start = 1'b0;
            chk(copy_valid == (k < n), {req, " R8 copy_valid"}, int'(copy_valid), int'(k < n));
            if (k < n && copy_valid) begin
                chk(copy_src == REG_AW'(es[k]), {req, " src reg"}, int'(copy_src), es[k]);
                chk(copy_dst == REG_AW'(ed[k]), {req, " dst reg"}, int'(copy_dst), ed[k]);
            end
            chk(done == (k == n), {req, " R9 done"}, int'(done), int'(k == n));
            if (k == n) begin
                chk(busy == 1'b0, {req, " R9 busy at done"}, int'(busy), 0);
                break;
            end
        end
        @(negedge clk);
        chk(!busy && !copy_valid, {req, " R2 idle after move"}, int'(busy), 0);
        vl = '0; src_base = '0; dst_base = '0; src_vec = 0; dst_vec = 0;
        src_mask = '0; dst_mask = '0; start = 0;
    endtask

    task automatic t_reset();   // R1
        rst_n = 1'b0; start = 0; vl = '0; src_base = '0; dst_base = '0;
        src_vec = 0; dst_vec = 0; src_mask = '0; dst_mask = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !copy_valid && !done, "R1 in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !copy_valid && !done, "R1 after reset", int'(copy_valid), 0);
    endtask

    task automatic t_splat();          run_op("R5 splat",          5, 3, 8, 0, 1, 'h0000, 'hFFFF, 0); endtask
    task automatic t_sparse_splat();   run_op("R4 sparse splat",   8, 2, 10, 0, 1, 'hFFFF, 'h00A6, 0); endtask
    task automatic t_insert();         run_op("R4 insert",         8, 6, 12, 0, 1, 'h0000, 'h0010, 0); endtask
    task automatic t_extract();        run_op("R3 extract",        8, 4, 1, 1, 0, 'h0008, 'h0000, 0); endtask
    task automatic t_copy();           run_op("R3 copy",           16, 0, 16, 1, 1, 'hFFFF, 'hFFFF, 0); endtask
    task automatic t_gather();         run_op("R3 gather",         8, 1, 20, 1, 1, 'h0055, 'hFFFF, 0); endtask
    task automatic t_scatter();        run_op("R4 scatter",        8, 5, 14, 1, 1, 'hFFFF, 'h00C3, 0); endtask
    task automatic t_gather_scatter(); run_op("R7 gather-scatter", 12, 0, 12, 1, 1, 'h0111, 'h0F0F, 0); endtask
    task automatic t_zero_len();       run_op("R7 zero length",    0, 0, 8, 1, 1, 'hFFFF, 'hFFFF, 0); endtask
    task automatic t_scalar_pair();    run_op("R6 scalar pair",    4, 11, 22, 0, 0, 'h0000, 'h0000, 0); endtask
    task automatic t_scalar_zero();    run_op("R6 scalar len0",    0, 11, 22, 0, 0, 'h0000, 'h0000, 0); endtask
    task automatic t_high_bits();      run_op("R7 bits above len", 4, 0, 8, 1, 1, 'hFF05, 'hF00A, 0); endtask
    task automatic t_empty_mask();     run_op("R7 empty mask",     8, 0, 8, 1, 1, 'h0000, 'hFFFF, 0); endtask
    task automatic t_clamp();          run_op("R10 clamp",         20, 0, 16, 1, 1, 'hFFFF, 'hFFFF, 0); endtask
    task automatic t_wrap();           run_op("R11 wrap",          4, 30, 29, 1, 1, 'hFFFF, 'hFFFF, 0); endtask
    task automatic t_busy_ignore();    run_op("R2 busy ignore",    6, 2, 18, 1, 1, 'hFFFF, 'hFFFF, 1); endtask

    initial begin
        t_reset();
        t_splat();
        t_sparse_splat();
        t_insert();
        t_extract();
        t_copy();
        t_gather();
        t_scatter();
        t_gather_scatter();
        t_zero_len();
        t_scalar_pair();
        t_scalar_zero();
        t_high_bits();
        t_empty_mask();
        t_clamp();
        t_wrap();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule